// File: doc/BRIEF.md
# Program Status Register with Sticky Failure Flag

This block is the status register placed between a page-program sequencer and the host read path. It tracks two flags: a ready flag, which the sequencer drops while it works and raises again when it finishes, and a program-failure flag. The failure flag is sticky. The sequencer can set it, but only a host clear-status pulse can reset it. Every other bit of the status word reads as zero.

The host sees the status through a snapshot register. The snapshot is taken on the clock edge where the chip-select and output-enable inputs (both active low) are first seen low together. That is the moment the later of the two falls. The snapshot then holds until one of the enables is released and asserted again. The block also tells the sequencer whether a new program operation may start. A standing failure blocks every further program until the host clears it.

The status word is 8 bits wide. Bit 7 is the ready flag and bit 4 is the failure flag. The resulting codes are:

| Code | Meaning |
|------|---------|
| 00h | busy |
| 80h | finished without error |
| 90h | finished with a failure |

Top module: `pgs_status_top`

## Requirements
- R1: After reset the snapshot reads 80h, `prog_inhibit` is 0, and `prog_grant` follows `prog_req`.
- R2: Ready flag (bit 7). A cycle with `seq_done` high sets it to 1. Otherwise a cycle with `seq_busy` high clears it to 0. Otherwise it keeps its value. `seq_done` takes priority over `seq_busy`.
- R3: Failure flag (bit 4). A cycle with `seq_fail` high sets it to 1. It is cleared only by a cycle with `clr_stat` high. `seq_busy` and `seq_done` never clear it.
- R4: When `seq_fail` and `clr_stat` are high in the same cycle, the failure flag ends at 1.
- R5: Bits 6, 5, 3, 2, 1 and 0 of `rd_data` are always 0. The status codes are 00h while busy, 80h on success, 90h on failure, and 80h again after a clear.
- R6: `rd_data` is loaded only on a clock edge where `sel_n` and `oe_n` are both sampled low after not both being low on the previous edge. It holds at all other times, including while both enables stay low and the status changes.
- R7: `prog_inhibit` equals the registered failure flag. `prog_grant` is `prog_req` AND ready AND NOT failure, evaluated combinationally from the registered flags.
- R8: A snapshot captures the status as it stood before the capturing edge. Flag changes that the same edge commits are not included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seq_busy | input | 1 | Sequencer is working (clears ready) |
| seq_done | input | 1 | Sequencer finished pulse (sets ready) |
| seq_fail | input | 1 | Sequencer failure pulse (sets sticky failure flag) |
| clr_stat | input | 1 | Host clear-status pulse |
| sel_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_req | input | 1 | Sequencer asks to start a program |
| rd_data | output | 8 | Frozen status snapshot for the host |
| prog_inhibit | output | 1 | Failure flag set: programming blocked |
| prog_grant | output | 1 | Program start allowed this cycle |

## Verification
A wrong ready or failure flag becomes visible in the combinational `prog_grant` and in `prog_inhibit` in the cycle after the faulty update. It reaches `rd_data` only at the next read capture, one edge after both enables are seen low. A capture taken at the wrong moment shows up in one of two ways. Either a snapshot changes while the enables stay low, or the snapshot carries the value written on its own capturing edge. Both appear at the host pins one cycle after the edge. The sweep therefore drives every combination of the four sequencer and host controls from all four flag states and reads back through the normal read path each time.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  localparam int unsigned STAT_W_DEF   = 8;
  localparam int unsigned READY_POS_DEF = 7;
  localparam int unsigned FAIL_POS_DEF  = 4;

  typedef struct packed {
    logic ready;
    logic fail;
  } pgs_flags_t;

endpackage

// File: rtl/pgs_ready_track.sv
module pgs_ready_track (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic done_i,
  output logic ready_o
);

  logic ready_q;
  logic ready_d;
  logic ready_en;

  always_comb begin
    ready_en = done_i | busy_i;
    ready_d  = done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b1;
    end else if (ready_en) begin
      ready_q <= ready_d;
    end
  end

  assign ready_o = ready_q;

endmodule

// File: rtl/pgs_fail_flag.sv
module pgs_fail_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic fail_o
);

  logic fail_q;
  logic fail_d;
  logic fail_en;

  always_comb begin
    fail_en = set_i | clr_i;
    fail_d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
    end else if (fail_en) begin
      fail_q <= fail_d;
    end
  end

  assign fail_o = fail_q;

endmodule

// File: rtl/pgs_read_snap.sv
module pgs_read_snap #(
  parameter int unsigned        W       = 8,
  parameter logic [W-1:0]       RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_n,
  input  logic         oe_n,
  input  logic [W-1:0] live_i,
  output logic [W-1:0] snap_o
);

  logic         act;
  logic         act_q;
  logic         cap_en;
  logic [W-1:0] snap_q;

  always_comb begin
    act    = ~sel_n & ~oe_n;
    cap_en = act & ~act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_q <= RST_VAL;
    end else if (cap_en) begin
      snap_q <= live_i;
    end
  end

  assign snap_o = snap_q;

endmodule

// File: rtl/pgs_status_top.sv
module pgs_status_top #(
  parameter int unsigned STAT_W    = pgs_pkg::STAT_W_DEF,
  parameter int unsigned READY_POS = pgs_pkg::READY_POS_DEF,
  parameter int unsigned FAIL_POS  = pgs_pkg::FAIL_POS_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              seq_fail,
  input  logic              clr_stat,
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              prog_req,
  output logic [STAT_W-1:0] rd_data,
  output logic              prog_inhibit,
  output logic              prog_grant
);

  localparam logic [STAT_W-1:0] RST_WORD = STAT_W'(1) << READY_POS;

  logic              rst_meta_q;
  logic              rst_sync_q;
  pgs_pkg::pgs_flags_t flags;
  logic [STAT_W-1:0] live_word;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pgs_ready_track u_ready (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .busy_i  (seq_busy),
    .done_i  (seq_done),
    .ready_o (flags.ready)
  );

  pgs_fail_flag u_fail (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .set_i  (seq_fail),
    .clr_i  (clr_stat),
    .fail_o (flags.fail)
  );

  // assemble status word; unassigned positions read as zero
  for (genvar b = 0; b < STAT_W; b++) begin : g_word
    if (b == READY_POS) begin : g_rdy
      assign live_word[b] = flags.ready;
    end else if (b == FAIL_POS) begin : g_fail
      assign live_word[b] = flags.fail;
    end else begin : g_rsv
      assign live_word[b] = 1'b0;
    end
  end

  pgs_read_snap #(
    .W       (STAT_W),
    .RST_VAL (RST_WORD)
  ) u_snap (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .sel_n  (sel_n),
    .oe_n   (oe_n),
    .live_i (live_word),
    .snap_o (rd_data)
  );

  always_comb begin
    prog_inhibit = flags.fail;
    prog_grant   = prog_req & flags.ready & ~flags.fail;
  end

endmodule

// File: rtl/pgs_status_chk.sv
module pgs_status_chk #(
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned READY_POS = 7,
  parameter int unsigned FAIL_POS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_fail,
  input logic              clr_stat,
  input logic              sel_n,
  input logic              oe_n,
  input logic [STAT_W-1:0] rd_data,
  input logic              prog_inhibit,
  input logic              prog_grant
);

  localparam logic [STAT_W-1:0] RSV_MASK =
    ~((STAT_W'(1) << READY_POS) | (STAT_W'(1) << FAIL_POS));

  logic act_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b0;
    else        act_prev <= ~sel_n & ~oe_n;
  end

  // R3: the flag only drops after a clear with no concurrent set
  p_sticky_fail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_inhibit) |-> ($past(clr_stat) && !$past(seq_fail)));

  // R4: a set pulse always leaves the flag at 1
  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    seq_fail |=> prog_inhibit);

  // R5: reserved positions stay zero
  p_rsv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & RSV_MASK) == '0);

  // R6: snapshot holds unless a fresh read cycle begins
  p_snap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(~sel_n && ~oe_n && !act_prev) |=> $stable(rd_data));

  // R7: a standing failure never grants a program
  p_grant_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    prog_inhibit |-> !prog_grant);

endmodule

bind pgs_status_top pgs_status_chk #(
  .STAT_W    (STAT_W),
  .READY_POS (READY_POS),
  .FAIL_POS  (FAIL_POS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .seq_fail     (seq_fail),
  .clr_stat     (clr_stat),
  .sel_n        (sel_n),
  .oe_n         (oe_n),
  .rd_data      (rd_data),
  .prog_inhibit (prog_inhibit),
  .prog_grant   (prog_grant)
);

// File: tb/test_pgs_status_top.sv
module test_pgs_status_top;

  logic       clk;
  logic       rst_n;
  logic       seq_busy, seq_done, seq_fail, clr_stat;
  logic       sel_n, oe_n, prog_req;
  logic [7:0] rd_data;
  logic       prog_inhibit, prog_grant;

  int vec_cnt;
  int bad_cnt;
  logic m_ready, m_fail;

  pgs_status_top i_pgs_status_top (
    .clk          (clk),
    .rst_n        (rst_n),
    .seq_busy     (seq_busy),
    .seq_done     (seq_done),
    .seq_fail     (seq_fail),
    .clr_stat     (clr_stat),
    .sel_n        (sel_n),
    .oe_n         (oe_n),
    .prog_req     (prog_req),
    .rd_data      (rd_data),
    .prog_inhibit (prog_inhibit),
    .prog_grant   (prog_grant)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    vec_cnt++;
    if (got !== exp) begin
      bad_cnt++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] word(input logic r, input logic f);
    return {r, 2'b00, f, 4'b0000};
  endfunction

  // one control cycle; the model follows R2/R3/R4
  task automatic step(input logic b, input logic d, input logic f, input logic c);
    @(negedge clk);
    seq_busy = b; seq_done = d; seq_fail = f; clr_stat = c;
    @(posedge clk);
    if (d)      m_ready = 1'b1;
    else if (b) m_ready = 1'b0;
    if (f)      m_fail = 1'b1;
    else if (c) m_fail = 1'b0;
    #1;
    seq_busy = 0; seq_done = 0; seq_fail = 0; clr_stat = 0;
  endtask

  task automatic read_check(input string req);
    @(negedge clk);
    sel_n = 0; oe_n = 0;
    @(posedge clk);
    @(negedge clk);
    check(req, rd_data, word(m_ready, m_fail));
    check("R7 inhibit", {7'd0, prog_inhibit}, {7'd0, m_fail});
    prog_req = 1;
    #1;
    check("R7 grant", {7'd0, prog_grant}, {7'd0, m_ready & ~m_fail});
    prog_req = 0;
    sel_n = 1; oe_n = 1;
    @(posedge clk);
  endtask

  initial begin
    #2000000;
    bad_cnt++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    vec_cnt = 0; bad_cnt = 0;
    rst_n = 0;
    seq_busy = 0; seq_done = 0; seq_fail = 0; clr_stat = 0;
    sel_n = 1; oe_n = 1; prog_req = 0;
    m_ready = 1; m_fail = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state
    @(negedge clk);
    check("R1 snapshot", rd_data, 8'h80);
    check("R1 inhibit", {7'd0, prog_inhibit}, 8'h00);
    prog_req = 1; #1;
    check("R1 grant", {7'd0, prog_grant}, 8'h01);
    prog_req = 0;

    // R2 R3 R4 R5: every control combination from every flag state
    for (int st = 0; st < 4; st++) begin
      for (int cmb = 0; cmb < 16; cmb++) begin
        step(0, 1, 0, 1);
        if (st[1]) step(0, 0, 1, 0);
        if (!st[0]) step(1, 0, 0, 0);
        step(cmb[3], cmb[2], cmb[1], cmb[0]);
        read_check("R2/R3/R4/R5 sweep");
      end
    end

    // R5: the named code sequence
    step(0, 1, 0, 1);
    step(1, 0, 0, 0); read_check("R5 code busy 00h");
    step(0, 1, 0, 0); read_check("R5 code done 80h");
    step(1, 0, 0, 0); step(0, 1, 1, 0); read_check("R5 code fail 90h");
    step(1, 0, 0, 0); step(0, 1, 0, 0); read_check("R3 fail survives done");
    step(0, 0, 0, 1); read_check("R5 code cleared 80h");

    // R6: capture on the later enable, then hold
    @(negedge clk) oe_n = 0;
    step(1, 0, 0, 0);
    @(negedge clk) sel_n = 0;
    @(posedge clk);
    @(negedge clk) check("R6 later edge capture", rd_data, 8'h00);
    step(0, 1, 1, 0);
    @(negedge clk) check("R6 hold while low", rd_data, 8'h00);
    oe_n = 1;
    @(negedge clk) check("R6 hold when released", rd_data, 8'h00);
    oe_n = 0;
    @(posedge clk);
    @(negedge clk) check("R6 recapture", rd_data, 8'h90);
    sel_n = 1; oe_n = 1;

    // R8: capture edge coincides with a clear
    @(negedge clk);
    sel_n = 0; oe_n = 0; clr_stat = 1;
    @(posedge clk);
    m_fail = 0;
    #1 clr_stat = 0;
    @(negedge clk) check("R8 pre-edge value", rd_data, 8'h90);
    sel_n = 1; oe_n = 1;
    @(posedge clk);
    read_check("R8 next read");

    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule